// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the byte-wide host-side register interface of an audio codec. Four direct ports sit on a 2-bit address. The host selects one of up to 32 indirect 8-bit control registers through the index port. It then reaches that register through the data port. A status port carries the interrupt flag, and a programmed-I/O data port is decoded but inert.

Writes arrive as single-cycle strobes on `wr_en`. Reads are combinational from `rd_addr`, and `rd_en` marks the cycle in which a read is taken. Most indirect registers are plain storage. A few follow their own write rules:

- The sample-format register accepts changes only while a mode-change window is open.
- The mode register exposes a single writable bit. That bit widens the index from 4 to 5 bits.
- The read-only error/init register emulates a short calibration-busy indication after the mode-change window opens.

A playback-count event from outside (`set_pi`) raises the interrupt. The host clears it through the status port or by acknowledging the pending bit in the alternate status register. All indirect register values are exported flat for the datapath that uses them.

Top module: `codec_regfile`

## Requirements
- R1: After reset the index port reads 0x40, the status port reads 0x00, and the indirect registers hold these values: 0x88 at 2, 3, 4, 5, 18 and 19; 0x80 at 6 and 7; 0x08 at 9; 0x8A at 12; 0xA0 at 25 and 26; 0x00 elsewhere.
- R2: Direct port addresses are fixed as follows: index at 0, indexed data at 1, status at 2, PIO data at 3. A write to the index port stores data bits 6:0, and bit 7 always stores and reads as 0.
- R3: Bit 6 of register 12 selects extended mode. Only that bit of register 12 is writable. In basic mode the effective index is index bits 3:0, and in extended mode it is index bits 4:0.
- R4: A write to register 8 stores all bits when index bit 6 (the mode-change enable) is 1. Otherwise, if bit 4 of register 24 is 1, it stores data bits 7:4 and keeps bits 3:0. Otherwise the write is dropped.
- R5: Register 9 bit 5 always stores 0. Writes to register 11 and to indices 22, 27 and 29 change nothing. Writes to the PIO port change nothing, and that port reads 0x00.
- R6: A busy count is loaded with 1 by an index-port write that takes index bit 6 from 0 to 1 while bits 4:3 of register 9 are not both 0. A data-port read of register 11 while the count is nonzero returns bit 5 set and decrements the count. Once the count is zero, bit 5 reads as stored (0).
- R7: Any status-port write clears status bit 0 and bits 6:4 of register 24. A write to register 24 with data bit 4 at 0, while that bit was 1, also clears status bit 0.
- R8: `set_pi` sets status bit 0 and bit 4 of register 24 on the next edge. If a clear happens in the same cycle, the set wins. `irq` always equals status bit 0.
- R9: Every other indirect register stores the full written byte and reads it back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 2 | Direct port selected for the write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Marks the cycle in which a read is taken |
| rd_addr | input | 2 | Direct port selected for the read |
| rd_data | output | 8 | Combinational read data |
| set_pi | input | 1 | Playback-count interrupt request |
| irq | output | 1 | Interrupt line, equal to status bit 0 |
| ext_mode | output | 1 | Extended (5-bit index) mode active |
| ireg_flat | output | 256 | All indirect registers, register n at bits 8n+7:8n |

## Verification
Most state errors surface within one read. A wrong write rule or a wrong index fold shows on the next data-port read of the affected index as a wrong byte. A mode bit that fails to flip shows as an alias: a 5-bit index lands on the register 16 below it. A busy count that is loaded wrongly or never drained shows as a stuck or missing bit 5 on the first or second read of register 11 after the mode-change window opens. Interrupt state errors show on `irq` one edge after the set or clear strobe, and in bits 6:4 of register 24 on the next read.

// File: rtl/codec_regfile_pkg.sv
package codec_regfile_pkg;

  localparam int DW       = 8;
  localparam int NREG     = 32;
  localparam int AW       = $clog2(NREG);
  localparam int BASIC_AW = 4;

  typedef enum logic [1:0] {
    PORT_IDX  = 2'd0,
    PORT_DATA = 2'd1,
    PORT_STAT = 2'd2,
    PORT_PIO  = 2'd3
  } port_e;

  localparam int RG_FMT   = 8;
  localparam int RG_IFC   = 9;
  localparam int RG_CAL   = 11;
  localparam int RG_MODE  = 12;
  localparam int RG_IRQST = 24;

  localparam int MCE_BIT  = 6;
  localparam int EXT_BIT  = 6;
  localparam int PI_BIT   = 4;
  localparam int BUSY_BIT = 5;

  function automatic logic [DW-1:0] reg_reset(input int i);
    case (i)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] apply_write(input int i, input logic [DW-1:0] old,
                                                input logic [DW-1:0] wd, input logic mce,
                                                input logic pmce);
    case (i)
      RG_FMT: begin
        if (mce)       return wd;
        else if (pmce) return {wd[7:4], old[3:0]};
        else           return old;
      end
      RG_IFC:             return wd & 8'hDF;
      RG_CAL, 22, 27, 29: return old;
      RG_MODE:            return {old[7], wd[EXT_BIT], old[5:0]};
      default:            return wd;
    endcase
  endfunction

endpackage

// File: rtl/codec_index_fold.sv
module codec_index_fold #(
  parameter int WIDE   = 5,
  parameter int NARROW = 4
) (
  input  logic [WIDE-1:0] raw,
  input  logic            wide_mode,
  output logic [WIDE-1:0] idx
);
  generate
    if (NARROW < WIDE) begin : g_fold
      always_comb begin
        if (wide_mode) idx = raw;
        else           idx = {{(WIDE-NARROW){1'b0}}, raw[NARROW-1:0]};
      end
    end else begin : g_pass
      logic unused_mode;
      assign unused_mode = wide_mode;
      assign idx = raw;
    end
  endgenerate
endmodule

// File: rtl/codec_cal_busy.sv
module codec_cal_busy #(
  parameter int LOAD = 1,
  parameter int W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic take,
  output logic busy
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (arm)          cnt_q <= W'(LOAD);
    else if (take && busy) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R6
  cal_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && busy && !arm) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6
  cal_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> busy);
endmodule

// File: rtl/codec_ireg_bank.sv
module codec_ireg_bank
  import codec_regfile_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          mce,
  input  logic          stat_clr,
  input  logic          set_pi,
  output logic [DW-1:0] regs [NREG],
  output logic          pi_ack
);
  logic          pmce;
  logic [DW-1:0] nxt [NREG];

  assign pmce   = regs[RG_IRQST][PI_BIT];
  assign pi_ack = we && (widx == AW'(RG_IRQST)) && pmce && !wdata[PI_BIT];

  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      nxt[k] = regs[k];
      if (we && (widx == AW'(k))) nxt[k] = apply_write(k, regs[k], wdata, mce, pmce);
    end
    if (stat_clr) nxt[RG_IRQST] = nxt[RG_IRQST] & 8'h8F;
    if (set_pi)   nxt[RG_IRQST][PI_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs[k] <= reg_reset(k);
    end else begin
      for (int k = 0; k < NREG; k++) regs[k] <= nxt[k];
    end
  end

  // R4
  fmt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == AW'(RG_FMT) && !mce && !pmce) |=> $stable(regs[RG_FMT]));

  // R4
  fmt_keep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == AW'(RG_FMT) && !mce) |=> (regs[RG_FMT][3:0] == $past(regs[RG_FMT][3:0])));

  // R5
  ro_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> $stable(regs[RG_CAL]));

  // R3
  mode_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ($stable(regs[RG_MODE][7]) && $stable(regs[RG_MODE][5:0])));

  // R8
  pi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_pi |=> regs[RG_IRQST][PI_BIT]);
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regfile_pkg::*;
#(
  parameter int CAL_LOAD = 1,
  parameter int CAL_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  input  logic [1:0]         rd_addr,
  output logic [DW-1:0]      rd_data,
  input  logic               set_pi,
  output logic               irq,
  output logic               ext_mode,
  output logic [NREG*DW-1:0] ireg_flat
);
  logic [DW-1:0] idx_q;
  logic          st_q;
  logic [AW-1:0] idx_eff;
  logic [DW-1:0] ireg [NREG];
  logic          pi_ack;
  logic          cal_busy;

  // named events for the assertions
  logic wr_idx, wr_dat, wr_stat, cal_arm, cal_take;

  assign wr_idx   = wr_en && (port_e'(wr_addr) == PORT_IDX);
  assign wr_dat   = wr_en && (port_e'(wr_addr) == PORT_DATA);
  assign wr_stat  = wr_en && (port_e'(wr_addr) == PORT_STAT);
  assign cal_arm  = wr_idx && !idx_q[MCE_BIT] && wr_data[MCE_BIT]
                    && (ireg[RG_IFC][4:3] != 2'b00);
  assign cal_take = rd_en && (port_e'(rd_addr) == PORT_DATA) && (idx_eff == AW'(RG_CAL));
  assign ext_mode = ireg[RG_MODE][EXT_BIT];
  assign irq      = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= 8'h40;
    else if (wr_idx) idx_q <= {1'b0, wr_data[6:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  st_q <= 1'b0;
    else if (set_pi)             st_q <= 1'b1;
    else if (wr_stat || pi_ack)  st_q <= 1'b0;
  end

  codec_index_fold #(.WIDE(AW), .NARROW(BASIC_AW)) u_fold (
    .raw       (idx_q[AW-1:0]),
    .wide_mode (ext_mode),
    .idx       (idx_eff)
  );

  codec_ireg_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_dat),
    .widx     (idx_eff),
    .wdata    (wr_data),
    .mce      (idx_q[MCE_BIT]),
    .stat_clr (wr_stat),
    .set_pi   (set_pi),
    .regs     (ireg),
    .pi_ack   (pi_ack)
  );

  codec_cal_busy #(.LOAD(CAL_LOAD), .W(CAL_W)) u_cal (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (cal_arm),
    .take  (cal_take),
    .busy  (cal_busy)
  );

  always_comb begin
    case (port_e'(rd_addr))
      PORT_IDX:  rd_data = idx_q;
      PORT_DATA: begin
        rd_data = ireg[idx_eff];
        if (cal_busy && (idx_eff == AW'(RG_CAL))) rd_data[BUSY_BIT] = 1'b1;
      end
      PORT_STAT: rd_data = {7'b0, st_q};
      default:   rd_data = 8'h00;
    endcase
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign ireg_flat[g*DW +: DW] = ireg[g];
    end
  endgenerate

  // R2
  idx_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> (idx_q[7] == 1'b0) && (idx_q[6:0] == $past(wr_data[6:0])));

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_pi |=> irq);

  // R7
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_stat || pi_ack) && !set_pi) |=> !irq);

  // R7
  stat_clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !set_pi) |=> (ireg[RG_IRQST][6:4] == 3'b000));
endmodule

// File: tb/codec_regfile_tb_top.sv
`timescale 1ns/1ps
module codec_regfile_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [7:0]   wr_data = 8'h00;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_addr = 2'd0;
  logic [7:0]   rd_data;
  logic         set_pi = 1'b0;
  logic         irq;
  logic         ext_mode;
  logic [255:0] ireg_flat;

  int checks = 0;
  int errors = 0;

  // bench-side model of the register file
  logic [7:0] mdl [32];
  logic [7:0] midx;
  logic [7:0] mstat;
  int         mcnt;

  always #2 clk = ~clk;

  codec_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .set_pi(set_pi),
    .irq(irq), .ext_mode(ext_mode), .ireg_flat(ireg_flat)
  );

  function automatic logic [7:0] expect_reset(input int n);
    logic [7:0] v;
    v = 8'h00;
    if ((n >= 2 && n <= 5) || n == 18 || n == 19) v = 8'h88;
    if (n == 6 || n == 7)   v = 8'h80;
    if (n == 9)             v = 8'h08;
    if (n == 12)            v = 8'h8A;
    if (n == 25 || n == 26) v = 8'hA0;
    return v;
  endfunction

  function automatic int cur_index();
    if (mdl[12][6]) return int'(midx % 32);
    return int'(midx % 16);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic model_pi();
    mstat[0] = 1'b1;
    mdl[24][4] = 1'b1;
  endtask

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    int n;
    if (a == 2'd0) begin
      if (midx[6] == 1'b0 && d[6] == 1'b1 && (mdl[9] & 8'h18) != 8'h00) mcnt = 1;
      midx = d & 8'h7F;
    end else if (a == 2'd1) begin
      n = cur_index();
      if (n == 11 || n == 22 || n == 27 || n == 29) begin
      end else if (n == 8) begin
        if (midx[6]) mdl[8] = d;
        else if (mdl[24][4]) mdl[8] = (d & 8'hF0) | (mdl[8] & 8'h0F);
      end else if (n == 9) begin
        mdl[9] = d & ~8'h20;
      end else if (n == 12) begin
        mdl[12] = (mdl[12] & 8'hBF) | (d & 8'h40);
      end else if (n == 24) begin
        if (mdl[24][4] && !d[4]) mstat[0] = 1'b0;
        mdl[24] = d;
      end else begin
        mdl[n] = d;
      end
    end else if (a == 2'd2) begin
      mstat = 8'h00;
      mdl[24] = mdl[24] & 8'h8F;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic pi);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; set_pi = pi;
    model_write(a, d);
    if (pi) model_pi();
    @(negedge clk);
    wr_en = 1'b0; set_pi = 1'b0;
  endtask

  task automatic pulse_pi();
    @(negedge clk);
    set_pi = 1'b1;
    model_pi();
    @(negedge clk);
    set_pi = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input string req);
    logic [7:0] e;
    int n;
    @(negedge clk);
    rd_addr = a; rd_en = 1'b1;
    #1;
    case (a)
      2'd0: e = midx;
      2'd1: begin
        n = cur_index();
        e = mdl[n];
        if (n == 11 && mcnt > 0) begin
          e = e | 8'h20;
          mcnt--;
        end
      end
      2'd2: e = mstat;
      default: e = 8'h00;
    endcase
    check(req, rd_data, e);
    if (a == 2'd2) check({req, " irq"}, {7'b0, irq}, {7'b0, mstat[0]});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_ireg(input logic [7:0] index_val, input string req);
    wr(2'd0, index_val, 1'b0);
    rd_chk(2'd1, req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] pats [4];
    pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h5A;
    for (int k = 0; k < 32; k++) mdl[k] = expect_reset(k);
    midx = 8'h40; mstat = 8'h00; mcnt = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state of the direct ports
    rd_chk(2'd0, "R1 index reset");
    rd_chk(2'd2, "R1 status reset");
    rd_chk(2'd3, "R5 pio read");
    check("R3 ext_mode reset", {7'b0, ext_mode}, 8'h00);
    // R1 basic-mode registers
    for (int k = 0; k < 16; k++) rd_ireg(8'h40 | 8'(k), "R1 indirect reset");
    // R3 enter extended mode: only bit 6 of register 12 changes
    wr(2'd0, 8'h4C, 1'b0);
    wr(2'd1, 8'hFF, 1'b0);
    rd_chk(2'd1, "R3 mode register mask");
    check("R3 ext_mode on", {7'b0, ext_mode}, 8'h01);
    for (int k = 16; k < 32; k++) rd_ireg(8'h40 | 8'(k), "R1 indirect reset high");

    // R9 R5 R4 R3 sweep of all indices with several patterns
    for (int k = 0; k < 32; k++) begin
      for (int p = 0; p < 4; p++) begin
        wr(2'd0, 8'h40 | 8'(k), 1'b0);
        wr(2'd1, pats[p], 1'b0);
        rd_chk(2'd1, "R9 sweep readback");
      end
    end
    // restore extended mode, clear interrupt state
    wr(2'd0, 8'h4C, 1'b0);
    wr(2'd1, 8'h40, 1'b0);
    wr(2'd2, 8'h00, 1'b0);

    // R2 bit 7 of index never stored
    wr(2'd0, 8'hC3, 1'b0);
    rd_chk(2'd0, "R2 index bit7");
    for (int k = 0; k < 32; k++) check("R9 exported registers", ireg_flat[k*8 +: 8], mdl[k]);

    // R4 format gating without mode-change enable
    wr(2'd0, 8'h18, 1'b0); wr(2'd1, 8'h00, 1'b0);
    wr(2'd0, 8'h08, 1'b0); wr(2'd1, 8'h3C, 1'b0);
    rd_chk(2'd1, "R4 format write dropped");
    wr(2'd0, 8'h18, 1'b0); wr(2'd1, 8'h10, 1'b0);
    wr(2'd0, 8'h08, 1'b0); wr(2'd1, 8'hF7, 1'b0);
    rd_chk(2'd1, "R4 format partial write");
    wr(2'd0, 8'h48, 1'b0); wr(2'd1, 8'h96, 1'b0);
    rd_chk(2'd1, "R4 format full write");

    // R6 calibration busy: register 9 bits 4:3 nonzero
    wr(2'd0, 8'h49, 1'b0); wr(2'd1, 8'h18, 1'b0);
    wr(2'd0, 8'h0B, 1'b0);
    wr(2'd0, 8'h4B, 1'b0);
    rd_chk(2'd1, "R6 busy first read");
    rd_chk(2'd1, "R6 busy drained");
    // R6 no load when bits 4:3 are zero
    wr(2'd0, 8'h49, 1'b0); wr(2'd1, 8'hE7, 1'b0);
    rd_chk(2'd1, "R5 reg9 bit5 forced low");
    wr(2'd0, 8'h0B, 1'b0);
    wr(2'd0, 8'h4B, 1'b0);
    rd_chk(2'd1, "R6 no busy when disabled");
    // R6 no load when index bit 6 already set
    wr(2'd0, 8'h49, 1'b0); wr(2'd1, 8'h08, 1'b0);
    wr(2'd0, 8'h4B, 1'b0);
    rd_chk(2'd1, "R6 no busy without rising edge");

    // R3 basic mode aliasing
    wr(2'd0, 8'h4C, 1'b0); wr(2'd1, 8'h00, 1'b0);
    check("R3 ext_mode off", {7'b0, ext_mode}, 8'h00);
    wr(2'd0, 8'h5A, 1'b0); wr(2'd1, 8'h6E, 1'b0);
    rd_chk(2'd1, "R3 basic index alias");
    wr(2'd0, 8'h4A, 1'b0);
    rd_chk(2'd1, "R3 basic alias target");
    wr(2'd0, 8'h4C, 1'b0); wr(2'd1, 8'h40, 1'b0);
    rd_ireg(8'h5A, "R3 extended high register");

    // R8 R7 interrupt set and clears
    pulse_pi();
    rd_chk(2'd2, "R8 status set");
    rd_ireg(8'h58, "R8 pending bit set");
    wr(2'd1, 8'h70, 1'b0);
    wr(2'd2, 8'h5A, 1'b0);
    rd_chk(2'd2, "R7 status cleared by port write");
    rd_chk(2'd1, "R7 pending bits cleared");
    pulse_pi();
    wr(2'd0, 8'h58, 1'b0);
    wr(2'd1, 8'h01, 1'b0);
    rd_chk(2'd2, "R7 status cleared by acknowledge");
    rd_chk(2'd1, "R7 acknowledge stored");
    pulse_pi();
    wr(2'd2, 8'h00, 1'b1);
    rd_chk(2'd2, "R8 set wins over port clear");
    rd_chk(2'd1, "R8 pending set wins");
    wr(2'd1, 8'h00, 1'b1);
    rd_chk(2'd2, "R8 set wins over acknowledge");
    rd_chk(2'd1, "R8 pending kept on acknowledge");

    // R5 PIO writes ignored
    wr(2'd3, 8'hFF, 1'b0);
    rd_chk(2'd3, "R5 pio ignored");
    rd_chk(2'd2, "R5 pio no status effect");
    rd_chk(2'd0, "R5 pio no index effect");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule